// File: doc/BRIEF.md
# Line 21 Caption Waveform Encoder

This block places two caption characters per field onto one video line as a digital luma override. Field one is coded on line 21 and field two on line 284. On a line-start strobe that matches an enabled field, the block waits a fixed number of 13.5 MHz pixel enables, then drives a level code sequence made of a clock run-in, three start bits and sixteen NRZ data bits. All of it is timed in half-periods of D, where D is one thirty-second of the line period.

The host writes seven-bit characters into per-field staging registers through a write strobe. The encoder appends an odd parity bit as bit 7 of each character. Once a field's characters have gone out, its staging register is cleared to zero, so a field that gets no fresh data sends null characters next time. A status bit per field drops on a write and rises once that data has been placed on the line. The luma path downstream takes `luma_code` in place of the video sample while `ovr_valid` is high.

Top module: `cc_line_encoder`

## Requirements
- R1: Under reset `ovr_valid` is 0, `luma_code` is the 0 IRE code (16) and both `cc_status` bits are 1.
- R2: A frame starts only on a `line_start` with `line_num`=21, `field_two`=0 and `f1_enable`=1, or with `line_num`=284, `field_two`=1 and `f2_enable`=1. Every other line leaves `ovr_valid` low.
- R3: `ovr_valid` first reads high after the 142nd `pix_en` clock edge that follows the `line_start` edge.
- R4: Time advances only on clock edges with `pix_en`=1. After k such edges in the frame, the half-bit slot is floor(64k/858), which gives two slots per D with D = 858/32 pixel periods.
- R5: Slots 0 to 8 alternate high, low, starting high (run-in). Slots 9 to 12 are low (start bits 0, 0). Slots 13 and 14 are high (start bit 1).
- R6: Slots 15 to 46 carry 16 bits, two slots each: character A bits 0 to 7, then character B bits 0 to 7, least significant bit first. Bit 7 of each character is odd parity over its 7 data bits.
- R7: A high bit is coded as 126 (50 IRE) and a low bit as 16 (0 IRE). While `ovr_valid` is low, `luma_code` is 16.
- R8: `ovr_valid` falls on the pix_en edge at which the slot would reach 47.
- R9: `wr_stb[i]` copies that field's two host characters into staging and clears `cc_status[i]` on the same edge. Bit 0 is field one and bit 1 is field two.
- R10: When a field's frame ends and no write for it occurred since the frame began, its staging is cleared and `cc_status[i]` rises. The next frame then sends 0x80, 0x80.
- R11: A write to the sending field at any edge from the frame start up to and including the ending edge wins. The new data is kept and the status stays 0.
- R12: A field that is disabled, or on a line that does not match, keeps its staging contents and status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | 13.5 MHz pixel enable |
| line_start | input | 1 | Line start strobe |
| line_num | input | 10 | Current line number |
| field_two | input | 1 | 1 in field two |
| f1_char_a | input | 7 | Field one first character |
| f1_char_b | input | 7 | Field one second character |
| f2_char_a | input | 7 | Field two first character |
| f2_char_b | input | 7 | Field two second character |
| f1_enable | input | 1 | Field one coding enable |
| f2_enable | input | 1 | Field two coding enable |
| wr_stb | input | 2 | Per-field staging write strobe |
| ovr_valid | output | 1 | Luma override active |
| luma_code | output | 8 | Override luma level code |
| cc_status | output | 2 | Per-field sent status |

## Verification
A host write and the end of that field's frame can land on the same clock edge. The write must then win: the staging holds the new characters and the status stays low. The bench provokes this by predicting the ending `pix_en` edge from its own slot arithmetic and raising `wr_stb` exactly there. It also writes in the middle of a frame. Each time, it judges the outcome from `cc_status` and from the characters sent on the next caption line of that field.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } cc_state_t;

  // character with odd parity appended as bit 7
  function automatic logic [7:0] with_odd_parity(input logic [6:0] d);
    return {~(^d), d};
  endfunction
endpackage

// File: rtl/cc_bit_timer.sv
module cc_bit_timer
  import cc_pkg::*;
#(
  parameter int LINE_CLKS = 858,
  parameter int HALF_STEP = 64,
  parameter int START_DLY = 142,
  parameter int LAST_SLOT = 46,
  parameter int SLOT_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              go,
  output logic              busy,
  output logic              sending,
  output logic [SLOT_W-1:0] slot,
  output logic              done
);
  localparam int ACC_W = $clog2(LINE_CLKS);
  localparam int DLY_W = $clog2(START_DLY + 1);
  localparam logic [ACC_W:0]      STEP_V    = (ACC_W+1)'(HALF_STEP);
  localparam logic [ACC_W:0]      LINE_V    = (ACC_W+1)'(LINE_CLKS);
  localparam logic [DLY_W-1:0]    DLY_LAST  = DLY_W'(START_DLY - 1);
  localparam logic [SLOT_W-1:0]   SLOT_LAST = SLOT_W'(LAST_SLOT);

  cc_state_t         st_q, st_n;
  logic [DLY_W-1:0]  cnt_q, cnt_n;
  logic [ACC_W-1:0]  acc_q, acc_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [ACC_W:0]    acc_sum;
  logic              wrap;

  assign acc_sum = {1'b0, acc_q} + STEP_V;
  assign wrap    = (acc_sum >= LINE_V);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    acc_n  = acc_q;
    slot_n = slot_q;
    done   = 1'b0;
    case (st_q)
      ST_IDLE: if (go) begin
        st_n  = ST_WAIT;
        cnt_n = '0;
      end
      ST_WAIT: if (pix_en) begin
        if (cnt_q == DLY_LAST) begin
          st_n   = ST_SEND;
          acc_n  = '0;
          slot_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_SEND: if (pix_en) begin
        if (wrap) begin
          acc_n = ACC_W'(acc_sum - LINE_V);
          if (slot_q == SLOT_LAST) begin
            done = 1'b1;
            st_n = ST_IDLE;
          end else begin
            slot_n = slot_q + 1'b1;
          end
        end else begin
          acc_n = ACC_W'(acc_sum);
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      acc_q  <= '0;
      slot_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      acc_q  <= acc_n;
      slot_q <= slot_n;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign sending = (st_q == ST_SEND);
  assign slot    = slot_q;

  // R4: phase stays inside one line period
  a_r4_acc_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, acc_q} < LINE_V);
  // R8: slot never runs past the last data half-bit
  a_r8_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sending |-> slot_q <= SLOT_LAST);
  // R8: frame end drops the send state
  a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !sending);
  // R3: a frame always begins at slot zero
  a_r3_send_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> slot_q == '0);
endmodule

// File: rtl/cc_stage.sv
module cc_stage #(
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          load,
  input  logic          done,
  input  logic [DW-1:0] host_a,
  input  logic [DW-1:0] host_b,
  output logic [DW-1:0] stg_a,
  output logic [DW-1:0] stg_b,
  output logic          ready
);
  logic [DW-1:0] a_q, a_n, b_q, b_n;
  logic          rdy_q, rdy_n, fresh_q, fresh_n;

  always_comb begin
    a_n     = a_q;
    b_n     = b_q;
    rdy_n   = rdy_q;
    fresh_n = fresh_q;
    if (load) fresh_n = 1'b0;
    if (wr) begin
      a_n     = host_a;
      b_n     = host_b;
      rdy_n   = 1'b0;
      fresh_n = 1'b1;
    end else if (done && !fresh_q) begin
      a_n   = '0;
      b_n   = '0;
      rdy_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      rdy_q   <= 1'b1;
      fresh_q <= 1'b0;
    end else begin
      a_q     <= a_n;
      b_q     <= b_n;
      rdy_q   <= rdy_n;
      fresh_q <= fresh_n;
    end
  end

  assign stg_a = a_q;
  assign stg_b = b_q;
  assign ready = rdy_q;

  // R9: a host write always drops the status
  a_r9_write_drops_status: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !ready);
  // R10: a completed frame with no newer write empties staging
  a_r10_done_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr && !fresh_q) |=> (ready && stg_a == '0 && stg_b == '0));
  // R12: nothing but a write or frame end touches staging
  a_r12_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !done) |=> ($stable(stg_a) && $stable(stg_b) && $stable(ready)));
endmodule

// File: rtl/cc_wave.sv
module cc_wave #(
  parameter int LVL_W  = 8,
  parameter int LVL_LO = 16,
  parameter int LVL_HI = 126,
  parameter int SLOT_W = 6
) (
  input  logic              sending,
  input  logic [SLOT_W-1:0] slot,
  input  logic [15:0]       word,
  output logic [LVL_W-1:0]  level
);
  localparam logic [SLOT_W-1:0] S_RUNIN_END = SLOT_W'(9);
  localparam logic [SLOT_W-1:0] S_ONE_BIT   = SLOT_W'(13);
  localparam logic [SLOT_W-1:0] S_DATA      = SLOT_W'(15);

  logic [SLOT_W-1:0] rel, half;
  logic              bit_hi;

  always_comb begin
    rel  = slot - S_DATA;
    half = rel >> 1;
    if (slot < S_RUNIN_END)    bit_hi = ~slot[0];
    else if (slot < S_ONE_BIT) bit_hi = 1'b0;
    else if (slot < S_DATA)    bit_hi = 1'b1;
    else                       bit_hi = |(word & (16'd1 << half));
    level = (sending && bit_hi) ? LVL_W'(LVL_HI) : LVL_W'(LVL_LO);
  end
endmodule

// File: rtl/cc_line_encoder.sv
module cc_line_encoder
  import cc_pkg::*;
#(
  parameter int LINE_CLKS   = 858,
  parameter int BITS_LINE   = 32,
  parameter int START_DLY   = 142,
  parameter int LINE_W      = 10,
  parameter int FIELD1_LINE = 21,
  parameter int FIELD2_LINE = 284,
  parameter int LVL_W       = 8,
  parameter int LVL_LO      = 16,
  parameter int LVL_HI      = 126
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_two,
  input  logic [6:0]        f1_char_a,
  input  logic [6:0]        f1_char_b,
  input  logic [6:0]        f2_char_a,
  input  logic [6:0]        f2_char_b,
  input  logic              f1_enable,
  input  logic              f2_enable,
  input  logic [1:0]        wr_stb,
  output logic              ovr_valid,
  output logic [LVL_W-1:0]  luma_code,
  output logic [1:0]        cc_status
);
  localparam int HALF_STEP = 2 * BITS_LINE;
  localparam int NUM_SLOTS = 15 + 2 * 16;
  localparam int LAST_SLOT = NUM_SLOTS - 1;
  localparam int SLOT_W    = $clog2(NUM_SLOTS + 1);
  localparam logic [LINE_W-1:0] L1 = LINE_W'(FIELD1_LINE);
  localparam logic [LINE_W-1:0] L2 = LINE_W'(FIELD2_LINE);

  logic [1:0]        rs_q;
  logic              rst_i;
  logic [1:0]        hit, load, fdone;
  logic              go, busy, sending, done, cur_q;
  logic [SLOT_W-1:0] slot;
  logic [15:0]       word_q, word_n;
  logic [6:0]        host_a [2];
  logic [6:0]        host_b [2];
  logic [6:0]        stg_a  [2];
  logic [6:0]        stg_b  [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign hit[0] = (line_num == L1) && !field_two && f1_enable;
  assign hit[1] = (line_num == L2) &&  field_two && f2_enable;
  assign go     = line_start && (|hit) && !busy;
  assign load   = go ? hit : 2'b00;
  assign fdone  = {done && cur_q, done && !cur_q};

  assign host_a[0] = f1_char_a;
  assign host_b[0] = f1_char_b;
  assign host_a[1] = f2_char_a;
  assign host_b[1] = f2_char_b;

  always_comb begin
    if (hit[1]) word_n = {with_odd_parity(stg_b[1]), with_odd_parity(stg_a[1])};
    else        word_n = {with_odd_parity(stg_b[0]), with_odd_parity(stg_a[0])};
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      word_q <= '0;
      cur_q  <= 1'b0;
    end else if (go) begin
      word_q <= word_n;
      cur_q  <= hit[1];
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_field
    cc_stage #(.DW(7)) u_stage (
      .clk(clk), .rst_n(rst_i), .wr(wr_stb[i]), .load(load[i]), .done(fdone[i]),
      .host_a(host_a[i]), .host_b(host_b[i]),
      .stg_a(stg_a[i]), .stg_b(stg_b[i]), .ready(cc_status[i])
    );
  end

  cc_bit_timer #(
    .LINE_CLKS(LINE_CLKS), .HALF_STEP(HALF_STEP), .START_DLY(START_DLY),
    .LAST_SLOT(LAST_SLOT), .SLOT_W(SLOT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_i), .pix_en(pix_en), .go(go),
    .busy(busy), .sending(sending), .slot(slot), .done(done)
  );

  cc_wave #(
    .LVL_W(LVL_W), .LVL_LO(LVL_LO), .LVL_HI(LVL_HI), .SLOT_W(SLOT_W)
  ) u_wave (
    .sending(sending), .slot(slot), .word(word_q), .level(luma_code)
  );

  assign ovr_valid = sending;

  // R7: no override means blank level on the luma code
  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_i)
    !ovr_valid |-> luma_code == LVL_W'(LVL_LO));
  // R7: only the two defined levels ever appear
  a_r7_two_levels: assert property (@(posedge clk) disable iff (!rst_i)
    ovr_valid |-> (luma_code == LVL_W'(LVL_LO) || luma_code == LVL_W'(LVL_HI)));
endmodule

// File: tb/sim_cc_line_encoder.sv
`timescale 1ns/1ps
module sim_cc_line_encoder;
  localparam int START = 142;
  localparam int LO = 16;
  localparam int HI = 126;

  logic clk = 1'b0;
  logic rst_n;
  logic pix_en, line_start, field_two, f1_enable, f2_enable;
  logic [9:0] line_num;
  logic [6:0] ha [2];
  logic [6:0] hb [2];
  logic [1:0] wr_stb;
  logic ovr_valid;
  logic [7:0] luma_code;
  logic [1:0] cc_status;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // bench model state
  int m_mode = 0, m_n = 0, m_k = 0, m_cur = 0;
  logic [15:0] m_word = '0;
  logic [6:0] m_sa [2] = '{7'd0, 7'd0};
  logic [6:0] m_sb [2] = '{7'd0, 7'd0};
  bit m_rdy [2] = '{1'b1, 1'b1};
  bit m_fresh [2] = '{1'b0, 1'b0};

  always #2 clk = ~clk;

  cc_line_encoder u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
    .line_num(line_num), .field_two(field_two),
    .f1_char_a(ha[0]), .f1_char_b(hb[0]), .f2_char_a(ha[1]), .f2_char_b(hb[1]),
    .f1_enable(f1_enable), .f2_enable(f2_enable), .wr_stb(wr_stb),
    .ovr_valid(ovr_valid), .luma_code(luma_code), .cc_status(cc_status)
  );

  function automatic logic [7:0] par8(input logic [6:0] d);
    return {~(^d), d};
  endfunction

  function automatic bit exp_hi(input int s, input logic [15:0] w);
    if (s < 9)  return (s % 2) == 0;
    if (s < 13) return 1'b0;
    if (s < 15) return 1'b1;
    return w[(s - 15) / 2];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model_step(input bit pix, input bit ls, input bit [1:0] wr);
    bit dn = 0;
    bit h1 = (line_num == 10'd21) && !field_two && f1_enable;
    bit h2 = (line_num == 10'd284) && field_two && f2_enable;
    if (m_mode == 0) begin
      if (ls && (h1 || h2)) begin
        m_cur = h2 ? 1 : 0;
        m_word = {par8(m_sb[m_cur]), par8(m_sa[m_cur])};
        m_fresh[m_cur] = 0;
        m_mode = 1;
        m_n = 0;
      end
    end else if (m_mode == 1) begin
      if (pix) begin
        m_n++;
        if (m_n == START) begin m_mode = 2; m_k = 0; end
      end
    end else if (pix) begin
      m_k++;
      if ((m_k * 64) / 858 >= 47) begin m_mode = 0; dn = 1; end
    end
    for (int i = 0; i < 2; i++) begin
      if (wr[i]) begin
        m_sa[i] = ha[i]; m_sb[i] = hb[i]; m_rdy[i] = 0; m_fresh[i] = 1;
      end else if (dn && m_cur == i && !m_fresh[i]) begin
        m_sa[i] = '0; m_sb[i] = '0; m_rdy[i] = 1;
      end
    end
  endtask

  task automatic tick(input bit pix, input bit ls, input bit [1:0] wr, input string vtag, input string stag);
    int s;
    bit ev;
    int el;
    pix_en = pix; line_start = ls; wr_stb = wr;
    @(posedge clk);
    model_step(pix, ls, wr);
    @(negedge clk);
    pix_en = 0; line_start = 0; wr_stb = 0;
    ev = (m_mode == 2);
    s  = (m_k * 64) / 858;
    el = (ev && exp_hi(s, m_word)) ? HI : LO;
    chk(ovr_valid == ev, vtag, "ovr_valid", ovr_valid, ev);
    if (!ev)         chk(luma_code == el, "R7", "idle luma", luma_code, el);
    else if (s < 15) chk(luma_code == el, "R5", "runin/start luma", luma_code, el);
    else             chk(luma_code == el, "R6", "data luma", luma_code, el);
    chk(cc_status == {m_rdy[1], m_rdy[0]}, stag, "status", cc_status, {m_rdy[1], m_rdy[0]});
  endtask

  task automatic host_write(input int f, input logic [6:0] a, input logic [6:0] b, input string stag);
    ha[f] = a; hb[f] = b;
    tick(1'b1, 1'b0, 2'(1 << f), "R2", stag);
  endtask

  // one line of 1200 clocks; optional write at cycle wr_cyc or on the frame's ending edge
  task automatic run_line(input int ln, input bit fld, input bit rnd_pix, input int wr_cyc,
                          input bit [1:0] wr_mask, input bit wr_on_done,
                          input string vtag, input string stag);
    line_num = 10'(ln); field_two = fld;
    tick(1'b1, 1'b1, 2'b00, vtag, stag);
    for (int c = 1; c < 1200; c++) begin
      bit p = rnd_pix ? (($urandom % 4) != 0) : 1'b1;
      bit [1:0] w = (c == wr_cyc) ? wr_mask : 2'b00;
      if (wr_on_done && m_mode == 2 && p && (((m_k + 1) * 64) / 858) >= 47)
        w[m_cur] = 1'b1;
      for (int i = 0; i < 2; i++)
        if (w[i]) begin ha[i] = 7'($urandom); hb[i] = 7'($urandom); end
      tick(p, 1'b0, w, vtag, stag);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; pix_en = 0; line_start = 0; field_two = 0; line_num = '0;
    f1_enable = 0; f2_enable = 0; wr_stb = 0;
    ha[0] = 0; hb[0] = 0; ha[1] = 0; hb[1] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ovr_valid == 1'b0, "R1", "reset valid", ovr_valid, 0);
    chk(luma_code == 8'(LO), "R1", "reset luma", luma_code, LO);
    chk(cc_status == 2'b11, "R1", "reset status", cc_status, 3);
    rst_n = 1;
    repeat (3) tick(1'b0, 1'b0, 2'b00, "R1", "R1");

    // R9, R3, R5, R6, R8: field one with known data, full-rate enable
    f1_enable = 1;
    host_write(0, 7'h41, 7'h00, "R9");
    run_line(21, 0, 0, 0, 2'b00, 0, "R3", "R10");
    // R10: nothing written, null characters 0x80 go out
    run_line(21, 0, 0, 0, 2'b00, 0, "R8", "R10");
    // R12, R2: field two disabled keeps staging and status
    host_write(1, 7'h2A, 7'h15, "R9");
    run_line(284, 1, 0, 0, 2'b00, 0, "R2", "R12");
    // R2: right line, wrong field flag
    run_line(21, 1, 0, 0, 2'b00, 0, "R2", "R12");
    run_line(100, 0, 0, 0, 2'b00, 0, "R2", "R12");
    // R4: gapped pixel enable on field two
    f2_enable = 1;
    run_line(284, 1, 1, 0, 2'b00, 0, "R4", "R10");
    // R11: write during a frame, then on the ending edge
    host_write(0, 7'h7F, 7'h01, "R9");
    run_line(21, 0, 1, 500, 2'b01, 0, "R11", "R11");
    run_line(21, 0, 0, 0, 2'b00, 1, "R11", "R11");
    run_line(21, 0, 1, 0, 2'b00, 0, "R6", "R11");
    run_line(21, 0, 0, 0, 2'b00, 0, "R10", "R10");

    // random mix
    for (int t = 0; t < 24; t++) begin
      int sel = $urandom % 3;
      int ln  = (sel == 0) ? 21 : (sel == 1) ? 284 : 30 + ($urandom % 500);
      bit fld = (sel == 1) ? (($urandom % 5) != 0) : (($urandom % 5) == 0);
      f1_enable = ($urandom % 4) != 0;
      f2_enable = ($urandom % 4) != 0;
      run_line(ln, fld, $urandom % 2, ($urandom % 3 == 0) ? 1 + $urandom % 1100 : 0,
               2'($urandom), ($urandom % 4) == 0, "R2", "R12");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule